// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog counter behind a small word-addressed register port. Once armed, a 32-bit counter climbs one step per slow timer tick (optionally divided by a power of two). When it rolls past all ones, the block emits a one-cycle reset request and restarts from the reload value. Software keeps the system alive by writing the trigger register with a value that differs from the one it holds. Each such write restarts the counter from the load register.

The watchdog can only be armed or disarmed through ordered pairs of key words written to a key register, so a stray store cannot switch it off. Writes to the control, load, trigger and key registers are not applied at once. They are held in a staging slot, and a per-register busy flag stays set until two timer ticks have passed. The write is applied on the second tick. This models the hand-over into a slow timer domain as a fixed tick delay.

Word addresses: 0 control, 1 load, 2 trigger, 3 key, 4 live count, 5 busy flags.

Top module: `kwdt_top`

## Requirements
- R1: After a synchronous active-low reset, the watchdog is disarmed and the count, load, control and trigger registers all read 0. The busy flags read 0 and `rst_req` is low.
- R2: A write to control, load, trigger or key sets busy bit 0, 2, 3 or 4 respectively. The bit stays set until the second tick after the write. On that tick's clock edge the write takes effect and the bit clears. Until then, a read of the register returns its old value.
- R3: A write to a register whose busy bit is set is ignored.
- R4: A key write of 0xBBBB followed by a key write of 0x4444 arms the watchdog. The counter does not advance on the edge where arming takes effect.
- R5: A key write of 0xAAAA followed by a key write of 0x5555 disarms the watchdog. The counter still advances on the edge where disarming takes effect, and holds afterwards.
- R6: A key word that does not complete a valid pair returns the key checker to idle and leaves the armed state unchanged. 0xAAAA or 0xBBBB always begins a new pair.
- R7: While armed with control bit 5 clear, the count rises by one on every tick. While disarmed, it holds.
- R8: With control bit 5 set, the count rises once every 2^N ticks, where N is control bits 4:2. A new control value takes effect from the tick after the one on which it is applied.
- R9: A trigger write whose value differs from the current trigger value loads the count from the load register when it takes effect. This happens even while disarmed. A write of an equal value leaves the count running.
- R10: When an armed count advances past 0xFFFFFFFF, it reloads from the load register, and `rst_req` is high for exactly the following clock cycle.
- R11: Reads return the live count, load, control, trigger and busy bits at their word addresses. The key register and unmapped addresses read 0, and `rdata` is 0 whenever `re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle slow timer tick |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| rdata | output | 32 | Read data, combinational |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
A corrupted key checker state shows up as a changed or unchanged count slope within two ticks after the second key word is applied. A busy flag that clears early or late is visible on the busy-flag read the cycle after the offending tick. Prescaler or trigger-compare faults move the live count read away from the tick-by-tick expected value by the next divided step. An expiry fault is seen as a missing or stretched `rst_req` one cycle after the wrapping tick.

// File: rtl/kwdt_pkg.sv
// Shared constants and types of the keyed watchdog.
// Assumes a 3-bit word address and 16-bit key words zero-extended on the bus.
package kwdt_pkg;
    localparam int ADDR_W = 3;
    localparam int PEND_W = 5;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LOAD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_TRIG  = 3'd2;
    localparam logic [ADDR_W-1:0] A_KEY   = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd4;
    localparam logic [ADDR_W-1:0] A_PEND  = 3'd5;

    // Busy-flag bit positions (software decodes these)
    localparam int PB_CTRL = 0;
    localparam int PB_LOAD = 2;
    localparam int PB_TRIG = 3;
    localparam int PB_KEY  = 4;

    // Staging slot order
    localparam int NSLOT  = 4;
    localparam int S_CTRL = 0;
    localparam int S_LOAD = 1;
    localparam int S_TRIG = 2;
    localparam int S_KEY  = 3;

    localparam logic [15:0] KEY_STOP_A  = 16'hAAAA;
    localparam logic [15:0] KEY_STOP_B  = 16'h5555;
    localparam logic [15:0] KEY_START_A = 16'hBBBB;
    localparam logic [15:0] KEY_START_B = 16'h4444;

    typedef enum logic [1:0] {
        KS_IDLE   = 2'd0,
        KS_STOP1  = 2'd1,
        KS_START1 = 2'd2
    } key_state_e;

    function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
        case (idx)
            S_CTRL:  return A_CTRL;
            S_LOAD:  return A_LOAD;
            S_TRIG:  return A_TRIG;
            default: return A_KEY;
        endcase
    endfunction
endpackage

// File: rtl/kwdt_pend_slot.sv
// One staging slot: captures a register write, holds a busy flag for
// PEND_TICKS timer ticks, then pulses commit for one cycle on the last tick.
// Assumes tick_en is a single-cycle strobe; writes while busy are dropped.
module kwdt_pend_slot #(
    parameter int DATA_W     = 32,
    parameter int PEND_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr,
    input  logic [DATA_W-1:0] wval,
    output logic              busy,
    output logic              commit,
    output logic [DATA_W-1:0] value
);
    localparam int TW = $clog2(PEND_TICKS + 1);
    localparam logic [TW-1:0] LAST = TW'(PEND_TICKS - 1);

    logic [TW-1:0] tcnt;

    // Last tick of the hand-over window
    assign commit = busy && tick_en && (tcnt == LAST);

    // Capture a write and count ticks until it is handed over
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            tcnt  <= '0;
            value <= '0;
        end else if (wr && !busy) begin
            busy  <= 1'b1;
            tcnt  <= '0;
            value <= wval;
        end else if (busy && tick_en) begin
            if (tcnt == LAST) busy <= 1'b0;
            else              tcnt <= tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/kwdt_keyseq.sv
// Key sequence checker: arms on START_A then START_B, disarms on STOP_A
// then STOP_B. Any other word returns to idle; a first word always restarts.
// Assumes commit is a one-cycle strobe from the key staging slot.
module kwdt_keyseq #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [DATA_W-1:0] val,
    output logic              armed
);
    import kwdt_pkg::*;

    localparam logic [DATA_W-1:0] K_SA = DATA_W'(KEY_STOP_A);
    localparam logic [DATA_W-1:0] K_SB = DATA_W'(KEY_STOP_B);
    localparam logic [DATA_W-1:0] K_GA = DATA_W'(KEY_START_A);
    localparam logic [DATA_W-1:0] K_GB = DATA_W'(KEY_START_B);

    key_state_e st;

    // Step the pair checker on each applied key word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= KS_IDLE;
            armed <= 1'b0;
        end else if (commit) begin
            if (st == KS_STOP1 && val == K_SB) begin
                armed <= 1'b0;
                st    <= KS_IDLE;
            end else if (st == KS_START1 && val == K_GB) begin
                armed <= 1'b1;
                st    <= KS_IDLE;
            end else if (val == K_SA) begin
                st <= KS_STOP1;
            end else if (val == K_GA) begin
                st <= KS_START1;
            end else begin
                st <= KS_IDLE;
            end
        end
    end
endmodule

// File: rtl/kwdt_core.sv
// Counting core: holds control, load and trigger registers, the prescaler
// and the up-counter; raises a one-cycle reset request on wrap while armed.
// Assumes commits arrive on tick edges; a trigger reload wins over a step.
module kwdt_core #(
    parameter int DATA_W    = 32,
    parameter int PSC_SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              armed,
    input  logic              ctrl_commit,
    input  logic [DATA_W-1:0] ctrl_val,
    input  logic              load_commit,
    input  logic [DATA_W-1:0] load_val,
    input  logic              trig_commit,
    input  logic [DATA_W-1:0] trig_val,
    output logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] trig_q,
    output logic              rst_req
);
    localparam int PSC_ON_BIT = PSC_SEL_W + 2;
    localparam int PSC_CW     = (1 << PSC_SEL_W) - 1;

    logic                 psc_on;
    logic [PSC_SEL_W-1:0] psc_sel;
    logic [PSC_CW-1:0]    psc_q;
    logic [PSC_CW-1:0]    psc_lim;
    logic                 psc_hit;
    logic                 trig_reload;
    logic                 step;
    logic                 wrap;

    assign psc_on      = ctrl_q[PSC_ON_BIT];
    assign psc_sel     = ctrl_q[PSC_ON_BIT-1:2];
    // Low psc_sel bits set: divide by 2**psc_sel
    assign psc_lim     = ~({PSC_CW{1'b1}} << psc_sel);
    assign psc_hit     = (psc_q == psc_lim);
    assign trig_reload = trig_commit && (trig_val != trig_q);
    assign step        = armed && tick_en && (!psc_on || psc_hit);
    assign wrap        = step && (count == {DATA_W{1'b1}});

    // Apply staged control, load and trigger values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '0;
            trig_q <= '0;
        end else begin
            if (ctrl_commit) ctrl_q <= ctrl_val;
            if (load_commit) load_q <= load_val;
            if (trig_commit) trig_q <= trig_val;
        end
    end

    // Prescaler: counts ticks between counter steps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else if (!armed || !psc_on || trig_reload) begin
            psc_q <= '0;
        end else if (tick_en) begin
            psc_q <= psc_hit ? '0 : psc_q + 1'b1;
        end
    end

    // Main counter with reload on trigger and on wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (trig_reload) begin
            count <= load_q;
        end else if (wrap) begin
            count <= load_q;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end

    // Registered one-cycle expiry pulse
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= wrap && !trig_reload;
    end
endmodule

// File: rtl/kwdt_top.sv
// Keyed watchdog top: register decode, four staging slots, key checker,
// counting core and combinational read mux.
// Assumes one access per cycle; writes to count/busy/unmapped are dropped.
module kwdt_top #(
    parameter int DATA_W     = 32,
    parameter int PEND_TICKS = 2,
    parameter int PSC_SEL_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_en,
    input  logic [kwdt_pkg::ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       we,
    input  logic                       re,
    output logic [DATA_W-1:0]          rdata,
    output logic                       rst_req
);
    import kwdt_pkg::*;

    logic [NSLOT-1:0]  slot_busy;
    logic [NSLOT-1:0]  slot_commit;
    logic [DATA_W-1:0] slot_val [NSLOT];
    logic [PEND_W-1:0] pend_w;
    logic              wd_en;
    logic              key_commit;
    logic [DATA_W-1:0] key_val;
    logic [DATA_W-1:0] cnt_w;
    logic [DATA_W-1:0] load_w;
    logic [DATA_W-1:0] ctrl_w;
    logic [DATA_W-1:0] trig_w;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        kwdt_pend_slot #(
            .DATA_W    (DATA_W),
            .PEND_TICKS(PEND_TICKS)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_en(tick_en),
            .wr     (we && (addr == slot_addr(i))),
            .wval   (wdata),
            .busy   (slot_busy[i]),
            .commit (slot_commit[i]),
            .value  (slot_val[i])
        );
    end

    // Busy flags in their software-visible positions
    always_comb begin
        pend_w          = '0;
        pend_w[PB_CTRL] = slot_busy[S_CTRL];
        pend_w[PB_LOAD] = slot_busy[S_LOAD];
        pend_w[PB_TRIG] = slot_busy[S_TRIG];
        pend_w[PB_KEY]  = slot_busy[S_KEY];
    end

    assign key_commit = slot_commit[S_KEY];
    assign key_val    = slot_val[S_KEY];

    kwdt_keyseq #(.DATA_W(DATA_W)) u_keys (
        .clk   (clk),
        .rst_n (rst_n),
        .commit(key_commit),
        .val   (key_val),
        .armed (wd_en)
    );

    kwdt_core #(
        .DATA_W   (DATA_W),
        .PSC_SEL_W(PSC_SEL_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .armed      (wd_en),
        .ctrl_commit(slot_commit[S_CTRL]),
        .ctrl_val   (slot_val[S_CTRL]),
        .load_commit(slot_commit[S_LOAD]),
        .load_val   (slot_val[S_LOAD]),
        .trig_commit(slot_commit[S_TRIG]),
        .trig_val   (slot_val[S_TRIG]),
        .count      (cnt_w),
        .load_q     (load_w),
        .ctrl_q     (ctrl_w),
        .trig_q     (trig_w),
        .rst_req    (rst_req)
    );

    // Read mux, zero when not reading
    always_comb begin
        rdata = '0;
        if (re) begin
            case (addr)
                A_CTRL:  rdata = ctrl_w;
                A_LOAD:  rdata = load_w;
                A_TRIG:  rdata = trig_w;
                A_COUNT: rdata = cnt_w;
                A_PEND:  rdata = DATA_W'(pend_w);
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/kwdt_checker.sv
// Property checker for kwdt_top, attached by bind below.
module kwdt_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [4:0]        pend,
    input logic              en,
    input logic [DATA_W-1:0] count,
    input logic              rst_req,
    input logic              key_commit,
    input logic [DATA_W-1:0] key_val
);
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ((pend & $past(pend)) == $past(pend))); // R2

    AST_PEND_BIT1_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !pend[1]); // R2

    AST_ARM_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> $past(key_commit && key_val == DATA_W'(16'h4444))); // R4

    AST_DISARM_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> $past(key_commit && key_val == DATA_W'(16'h5555))); // R5

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count)); // R7

    AST_NO_REQ_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !rst_req); // R10

    AST_REQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(tick_en)); // R10
endmodule

bind kwdt_top kwdt_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .pend      (pend_w),
    .en        (wd_en),
    .count     (cnt_w),
    .rst_req   (rst_req),
    .key_commit(key_commit),
    .key_val   (key_val)
);

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 54;
    // op: 0 write, 1 read/compare, 2 ticks(data = count)
    localparam logic [1:0] OW = 2'd0, OR = 2'd1, OT = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] rdata;
    logic        rst_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    kwdt_top dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
        .wdata(wdata), .we(we), .re(re), .rdata(rdata), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {req[3:0], op[1:0], addr[2:0], data[31:0], exp[31:0]}
    localparam logic [72:0] VEC [0:N-1] = '{
        {4'd1,  OR, 3'd5, 32'h0, 32'h0},          // R1 busy
        {4'd1,  OR, 3'd4, 32'h0, 32'h0},          // R1 count
        {4'd1,  OR, 3'd0, 32'h0, 32'h0},          // R1 ctrl
        {4'd0,  OW, 3'd1, 32'hFFFFFFF0, 32'h0},
        {4'd2,  OR, 3'd5, 32'h0, 32'h4},          // R2 load busy
        {4'd0,  OT, 3'd0, 32'd1, 32'h0},
        {4'd2,  OR, 3'd5, 32'h0, 32'h4},          // R2
        {4'd2,  OR, 3'd1, 32'h0, 32'h0},          // R2 old value
        {4'd0,  OT, 3'd0, 32'd1, 32'h0},
        {4'd2,  OR, 3'd5, 32'h0, 32'h0},          // R2
        {4'd2,  OR, 3'd1, 32'h0, 32'hFFFFFFF0},   // R2
        {4'd0,  OW, 3'd2, 32'h1, 32'h0},
        {4'd0,  OT, 3'd0, 32'd2, 32'h0},
        {4'd9,  OR, 3'd2, 32'h0, 32'h1},          // R9
        {4'd9,  OR, 3'd4, 32'h0, 32'hFFFFFFF0},   // R9 reload while disarmed
        {4'd0,  OW, 3'd3, 32'hBBBB, 32'h0},
        {4'd0,  OT, 3'd0, 32'd2, 32'h0},
        {4'd0,  OW, 3'd3, 32'h4444, 32'h0},
        {4'd0,  OT, 3'd0, 32'd1, 32'h0},
        {4'd2,  OR, 3'd5, 32'h0, 32'h10},         // R2 key busy
        {4'd0,  OT, 3'd0, 32'd1, 32'h0},
        {4'd4,  OR, 3'd4, 32'h0, 32'hFFFFFFF0},   // R4
        {4'd0,  OT, 3'd0, 32'd3, 32'h0},
        {4'd7,  OR, 3'd4, 32'h0, 32'hFFFFFFF3},   // R7
        {4'd0,  OW, 3'd2, 32'h1, 32'h0},
        {4'd0,  OT, 3'd0, 32'd2, 32'h0},
        {4'd9,  OR, 3'd4, 32'h0, 32'hFFFFFFF5},   // R9 equal value
        {4'd0,  OW, 3'd2, 32'h2, 32'h0},
        {4'd0,  OT, 3'd0, 32'd1, 32'h0},
        {4'd7,  OR, 3'd4, 32'h0, 32'hFFFFFFF6},   // R7
        {4'd0,  OT, 3'd0, 32'd1, 32'h0},
        {4'd9,  OR, 3'd4, 32'h0, 32'hFFFFFFF0},   // R9 new value
        {4'd0,  OW, 3'd0, 32'h24, 32'h0},
        {4'd2,  OR, 3'd5, 32'h0, 32'h1},          // R2 ctrl busy
        {4'd0,  OT, 3'd0, 32'd2, 32'h0},
        {4'd8,  OR, 3'd0, 32'h0, 32'h24},         // R8
        {4'd8,  OR, 3'd4, 32'h0, 32'hFFFFFFF2},   // R8
        {4'd0,  OT, 3'd0, 32'd1, 32'h0},
        {4'd8,  OR, 3'd4, 32'h0, 32'hFFFFFFF2},   // R8 divide by 2
        {4'd0,  OT, 3'd0, 32'd1, 32'h0},
        {4'd8,  OR, 3'd4, 32'h0, 32'hFFFFFFF3},   // R8
        {4'd0,  OW, 3'd3, 32'h5555, 32'h0},
        {4'd0,  OT, 3'd0, 32'd2, 32'h0},
        {4'd0,  OW, 3'd3, 32'hAAAA, 32'h0},
        {4'd0,  OT, 3'd0, 32'd2, 32'h0},
        {4'd0,  OW, 3'd3, 32'h1234, 32'h0},
        {4'd0,  OT, 3'd0, 32'd2, 32'h0},
        {4'd0,  OW, 3'd3, 32'h5555, 32'h0},
        {4'd0,  OT, 3'd0, 32'd2, 32'h0},
        {4'd6,  OR, 3'd4, 32'h0, 32'hFFFFFFF7},   // R6 still armed
        {4'd0,  OT, 3'd0, 32'd2, 32'h0},
        {4'd6,  OR, 3'd4, 32'h0, 32'hFFFFFFF8},   // R6
        {4'd11, OR, 3'd3, 32'h0, 32'h0},          // R11 key reads 0
        {4'd11, OR, 3'd6, 32'h0, 32'h0}           // R11 unmapped
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a; re = 1'b1;
        #1 v = rdata;
        re = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        do_reset();
        for (int i = 0; i < N; i++) begin
            logic [3:0]  rq;
            logic [1:0]  op;
            logic [2:0]  a;
            logic [31:0] d, e;
            {rq, op, a, d, e} = VEC[i];
            case (op)
                OW: wr(a, d);
                OT: ticks(int'(d));
                default: begin
                    rd(a, v);
                    check($sformatf("R%0d vec%0d", rq, i), v, e);
                end
            endcase
        end

        // R1: reset clears everything
        do_reset();
        rd(3'd4, v); check("R1 count", v, 32'h0);
        rd(3'd1, v); check("R1 load", v, 32'h0);
        rd(3'd2, v); check("R1 trig", v, 32'h0);
        rd(3'd5, v); check("R1 busy", v, 32'h0);
        check("R1 rst_req", {31'b0, rst_req}, 32'h0);

        // R10: expiry pulse and reload
        wr(3'd1, 32'hFFFFFFFE); ticks(2);
        wr(3'd2, 32'h5);        ticks(2);
        wr(3'd3, 32'hBBBB);     ticks(2);
        wr(3'd3, 32'h4444);     ticks(2);
        rd(3'd4, v); check("R10 start", v, 32'hFFFFFFFE);
        ticks(1);
        rd(3'd4, v); check("R10 top", v, 32'hFFFFFFFF);
        check("R10 no req yet", {31'b0, rst_req}, 32'h0);
        ticks(1);
        #1;
        check("R10 req high", {31'b0, rst_req}, 32'h1);
        rd(3'd4, v); check("R10 reloaded", v, 32'hFFFFFFFE);
        check("R10 one cycle", {31'b0, rst_req}, 32'h0);

        // R3: write while busy is dropped
        do_reset();
        wr(3'd1, 32'h7);
        wr(3'd1, 32'h9);
        ticks(2);
        rd(3'd1, v); check("R3 load kept", v, 32'h7);

        // R5: disarm pair, count steps on the disarm edge then holds
        wr(3'd3, 32'hBBBB); ticks(2);
        wr(3'd3, 32'h4444); ticks(2);
        rd(3'd4, v); check("R4 armed at 0", v, 32'h0);
        wr(3'd3, 32'hAAAA); ticks(2);
        rd(3'd4, v); check("R5 running", v, 32'h2);
        wr(3'd3, 32'h5555); ticks(2);
        rd(3'd4, v); check("R5 disarm edge", v, 32'h4);
        ticks(3);
        rd(3'd4, v); check("R5 holds", v, 32'h4);

        // R11: no read strobe gives zero
        @(negedge clk);
        addr = 3'd1; re = 1'b0;
        #1 check("R11 re low", rdata, 32'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule